// File: doc/BRIEF.md
# Decode Stage Queue Transfer

This block sits between a per-thread fetch queue and the micro-operation queue of a decode stage. In each cycle it looks at a window at the head of the fetch queue and decides how many entries move across. Each entry has a flag that marks trace-cache origin, a macro-op index that gives its position inside its parent instruction, a flag that says its instruction-cache fetch has finished, and a payload. Entries move only in whole-instruction units. A run of trace-cache entries moves in bulk and uses one decode slot. An ordinary instruction (a head with index zero plus the entries with nonzero index that follow it) moves in one slot, and only once its fetch has finished.

The block is combinational. The fetch-queue side is a valid/ready stream. `fq_valid` marks the visible entries, and only its contiguous prefix from lane 0 counts. `fq_pop` is the ready side: it gives how many head entries the queue must drop at the next clock edge. Back-pressure from the micro-operation queue comes only through its occupancy `uq_occ`. A slot may start while that occupancy, plus the entries already moved in this cycle, is below `UQ_SIZE`. A group that has started is never split, so the queue must hold `UQ_SIZE + MAX_MOVE` entries. Push lanes 0..`fq_pop`-1 are valid in fetch order.

Top module: `dxq_decode_xfer`

## Requirements
- R1: At most DECODE_WIDTH (default 4) slots are used per cycle. Processing stops once no visible entry is left at the current position. With no visible entry, `fq_pop` is 0 and no push lane is valid.
- R2: A slot starts only when `uq_occ` plus the number of entries already moved this cycle is below UQ_SIZE (default 16). With `uq_occ` at or above UQ_SIZE, nothing moves.
- R3: A head with the trace flag set moves together with every directly following visible trace-flagged entry, up to the window end. This uses one slot, and no further slot runs in that cycle.
- R4: A non-trace head whose fetch-done flag is 1 moves together with every directly following visible entry whose macro-op index is nonzero. This uses one slot, and later slots continue after the group.
- R5: A non-trace head whose fetch-done flag is 0 moves nothing but uses up its slot. Later slots see the same head, so nothing moves in that cycle.
- R6: Capacity is checked only when a slot starts. A group that has started moves completely, even if occupancy then goes past UQ_SIZE.
- R7: A non-trace group that would reach past the last window lane (all MAX_MOVE lanes visible and the group not closed) is held. Nothing moves in that slot, and the cycle ends.
- R8: `seq_err` is 1 when a slot examines a non-trace head whose macro-op index is nonzero. That head is still handled as in R4 and R5.
- R9: `fq_pop` equals the number of moved entries. Push lane i is valid exactly for i < `fq_pop`. Lane i carries window entry i packed as {in-queue bit = 1 (MSB), trace flag, macro-op index, payload (LSBs)}. Lanes that are not valid carry zero.
- R10: Only the contiguous run of `fq_valid` bits from lane 0 is visible. Entries after the first cleared bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fq_valid | input | MAX_MOVE | Per-lane valid for the fetch-queue head window |
| fq_trace | input | MAX_MOVE | Per-lane trace-cache origin flag |
| fq_done | input | MAX_MOVE | Per-lane instruction-fetch-complete flag |
| fq_mop | input | MAX_MOVE*MOP_W | Per-lane macro-op index, lane i at [i*MOP_W +: MOP_W] |
| fq_data | input | MAX_MOVE*DATA_W | Per-lane payload |
| uq_occ | input | clog2(UQ_SIZE+MAX_MOVE+1) | Current micro-operation queue occupancy |
| fq_pop | output | clog2(MAX_MOVE+1) | Entries to drop from the fetch-queue head |
| uq_push_valid | output | MAX_MOVE | Per-lane push valid into the micro-operation queue |
| uq_push_data | output | MAX_MOVE*(DATA_W+MOP_W+2) | Per-lane pushed entry |
| seq_err | output | 1 | A non-trace head with nonzero macro-op index was examined |

## Verification
Directed windows isolate each stopping cause. The decode width is shown by a run of single-entry instructions. The capacity cut-off is shown with occupancy just below and at the limit, and the overshoot comes from a multi-entry group that starts at occupancy 15. A trace run followed by a ready ordinary instruction shows that a trace run ends the cycle, and the reverse order shows that a group does not. A fetch still in flight, a group that fills the whole window versus one closed by an invalid lane, a broken valid prefix and a misnumbered head each take a separate path. Random instruction streams with random visibility, occupancy drain and fetch completion are then compared, lane by lane, with a bench reference.

// File: rtl/dxq_pkg.sv
package dxq_pkg;
  // What a single decode slot did in the current cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,  // slot not started
    ACT_TRACE = 2'd1,  // trace run moved
    ACT_GROUP = 2'd2,  // ordinary group moved
    ACT_WAIT  = 2'd3   // slot spent without moving
  } slot_act_e;
endpackage

// File: rtl/dxq_window.sv
// Reduces the raw valid bits to the visible contiguous prefix.
module dxq_window #(
  parameter int WIN = 8
) (
  input  logic [WIN-1:0] valid_in,
  output logic [WIN-1:0] vis
);
  assign vis[0] = valid_in[0];
  for (genvar i = 1; i < WIN; i++) begin : g_pref
    assign vis[i] = vis[i-1] & valid_in[i];
  end
endmodule

// File: rtl/dxq_slot.sv
// One decode slot: takes a start position and decides how far it advances.
module dxq_slot import dxq_pkg::*; #(
  parameter int WIN     = 8,
  parameter int MOP_W   = 3,
  parameter int UQ_SIZE = 16,
  parameter int OCC_W   = 5,
  parameter int PTR_W   = 4
) (
  input  logic [WIN-1:0]       vis,
  input  logic [WIN-1:0]       trace,
  input  logic [WIN-1:0]       done,
  input  logic [WIN*MOP_W-1:0] mop,
  input  logic [OCC_W-1:0]     uq_occ,
  input  logic [PTR_W-1:0]     ptr_in,
  input  logic                 stop_in,
  output logic [PTR_W-1:0]     ptr_out,
  output logic                 stop_out,
  output slot_act_e            act,
  output logic                 bad_head
);
  logic h_vis, h_trace, h_done, h_zero;
  int   run_end, grp_end;
  logic run_open, grp_found;

  // Head fields and the ends of a trace run / ordinary group from ptr_in
  always_comb begin
    h_vis = 1'b0; h_trace = 1'b0; h_done = 1'b0; h_zero = 1'b1;
    run_end = 0; run_open = 1'b1;
    grp_end = WIN; grp_found = 1'b0;
    for (int j = 0; j < WIN; j++) begin
      if (j == int'(ptr_in)) begin
        h_vis   = vis[j];
        h_trace = trace[j];
        h_done  = done[j];
        h_zero  = (mop[j*MOP_W +: MOP_W] == '0);
      end
      if (j >= int'(ptr_in) && run_open) begin
        if (vis[j] && trace[j]) run_end = j + 1;
        else                    run_open = 1'b0;
      end
      if (j > int'(ptr_in) && !grp_found &&
          (!vis[j] || mop[j*MOP_W +: MOP_W] == '0)) begin
        grp_end   = j;
        grp_found = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_out  = ptr_in;
    stop_out = stop_in;
    act      = ACT_IDLE;
    bad_head = 1'b0;
    if (!stop_in) begin
      if (!h_vis) begin
        stop_out = 1'b1;                             // nothing left
      end else if (int'(uq_occ) + int'(ptr_in) >= UQ_SIZE) begin
        stop_out = 1'b1;                             // queue at capacity
      end else if (h_trace) begin
        act      = ACT_TRACE;
        ptr_out  = PTR_W'(run_end);
        stop_out = 1'b1;                             // run ends the cycle
      end else begin
        bad_head = !h_zero;
        if (!h_done) begin
          act = ACT_WAIT;                            // fetch in flight
        end else if (grp_end == WIN) begin
          act      = ACT_WAIT;                       // group not closed in window
          stop_out = 1'b1;
        end else begin
          act     = ACT_GROUP;
          ptr_out = PTR_W'(grp_end);
        end
      end
    end
  end
endmodule

// File: rtl/dxq_lanes.sv
// Builds push lanes for the first pop_cnt window entries.
module dxq_lanes #(
  parameter int WIN    = 8,
  parameter int MOP_W  = 3,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4,
  parameter int ENT_W  = DATA_W + MOP_W + 2
) (
  input  logic [PTR_W-1:0]      pop_cnt,
  input  logic [WIN-1:0]        trace,
  input  logic [WIN*MOP_W-1:0]  mop,
  input  logic [WIN*DATA_W-1:0] data,
  output logic [WIN-1:0]        push_valid,
  output logic [WIN*ENT_W-1:0]  push_data
);
  for (genvar i = 0; i < WIN; i++) begin : g_lane
    assign push_valid[i] = (int'(pop_cnt) > i);
    assign push_data[i*ENT_W +: ENT_W] = push_valid[i] ?
      {1'b1, trace[i], mop[i*MOP_W +: MOP_W], data[i*DATA_W +: DATA_W]} : '0;
  end
endmodule

// File: rtl/dxq_decode_xfer.sv
module dxq_decode_xfer import dxq_pkg::*; #(
  parameter int DECODE_WIDTH = 4,
  parameter int MAX_MOVE     = 8,
  parameter int UQ_SIZE      = 16,
  parameter int MOP_W        = 3,
  parameter int DATA_W       = 16,
  localparam int PTR_W = $clog2(MAX_MOVE + 1),
  localparam int OCC_W = $clog2(UQ_SIZE + MAX_MOVE + 1),
  localparam int ENT_W = DATA_W + MOP_W + 2
) (
  input  logic [MAX_MOVE-1:0]        fq_valid,
  input  logic [MAX_MOVE-1:0]        fq_trace,
  input  logic [MAX_MOVE-1:0]        fq_done,
  input  logic [MAX_MOVE*MOP_W-1:0]  fq_mop,
  input  logic [MAX_MOVE*DATA_W-1:0] fq_data,
  input  logic [OCC_W-1:0]           uq_occ,
  output logic [PTR_W-1:0]           fq_pop,
  output logic [MAX_MOVE-1:0]        uq_push_valid,
  output logic [MAX_MOVE*ENT_W-1:0]  uq_push_data,
  output logic                       seq_err
);
  logic [MAX_MOVE-1:0]     fq_vis;
  logic [PTR_W-1:0]        ptr   [DECODE_WIDTH+1];
  logic                    stop  [DECODE_WIDTH+1];
  logic [DECODE_WIDTH-1:0] bad;
  logic [2*DECODE_WIDTH-1:0] act_bus;

  dxq_window #(.WIN(MAX_MOVE)) win_i (.valid_in(fq_valid), .vis(fq_vis));

  assign ptr[0]  = '0;
  assign stop[0] = 1'b0;

  for (genvar s = 0; s < DECODE_WIDTH; s++) begin : g_slot
    slot_act_e act_s;
    dxq_slot #(
      .WIN(MAX_MOVE), .MOP_W(MOP_W), .UQ_SIZE(UQ_SIZE),
      .OCC_W(OCC_W), .PTR_W(PTR_W)
    ) slot_i (
      .vis(fq_vis), .trace(fq_trace), .done(fq_done), .mop(fq_mop),
      .uq_occ(uq_occ), .ptr_in(ptr[s]), .stop_in(stop[s]),
      .ptr_out(ptr[s+1]), .stop_out(stop[s+1]),
      .act(act_s), .bad_head(bad[s])
    );
    assign act_bus[2*s +: 2] = act_s;
  end

  assign fq_pop  = ptr[DECODE_WIDTH];
  assign seq_err = |bad;

  dxq_lanes #(
    .WIN(MAX_MOVE), .MOP_W(MOP_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .ENT_W(ENT_W)
  ) lanes_i (
    .pop_cnt(fq_pop), .trace(fq_trace), .mop(fq_mop), .data(fq_data),
    .push_valid(uq_push_valid), .push_data(uq_push_data)
  );
endmodule

// File: rtl/dxq_decode_xfer_chk.sv
module dxq_decode_xfer_chk #(
  parameter int DW      = 4,
  parameter int WIN     = 8,
  parameter int UQ_SIZE = 16,
  parameter int MOP_W   = 3,
  parameter int OCC_W   = 5,
  parameter int PTR_W   = 4
) (
  input logic [WIN-1:0]       fq_valid,
  input logic [WIN-1:0]       fq_vis,
  input logic [WIN-1:0]       fq_trace,
  input logic [WIN-1:0]       fq_done,
  input logic [WIN*MOP_W-1:0] fq_mop,
  input logic [OCC_W-1:0]     uq_occ,
  input logic [PTR_W-1:0]     fq_pop,
  input logic [WIN-1:0]       uq_push_valid,
  input logic                 seq_err,
  input logic [2*DW-1:0]      act_bus
);
  logic edge_ok, after_trace, trace_ok;

  always_comb begin
    edge_ok = 1'b1;
    for (int j = 1; j < WIN; j++)
      if (int'(fq_pop) == j && fq_vis[j]) begin
        if (!fq_trace[j-1] && fq_mop[j*MOP_W +: MOP_W] != '0) edge_ok = 1'b0;
        if (fq_trace[j-1] && fq_trace[j]) edge_ok = 1'b0;
      end
    after_trace = 1'b0;
    trace_ok    = 1'b1;
    for (int s = 0; s < DW; s++) begin
      if (after_trace && act_bus[2*s +: 2] != 2'd0) trace_ok = 1'b0;
      if (act_bus[2*s +: 2] == 2'd1) after_trace = 1'b1;
    end
  end

  always_comb begin
    // R10
    lane_vis_chk: assert ((uq_push_valid & ~fq_vis) == '0);
    // R1
    empty_chk: assert (fq_valid[0] || fq_pop == '0);
    // R2
    full_stall_chk: assert (int'(uq_occ) < UQ_SIZE || fq_pop == '0);
    // R5
    fetch_wait_chk: assert (fq_pop == '0 || fq_trace[0] || fq_done[0]);
    // R8
    seq_err_chk: assert (!(fq_valid[0] && int'(uq_occ) < UQ_SIZE && !fq_trace[0]
                           && fq_mop[MOP_W-1:0] != '0) || seq_err);
    // R4
    group_edge_chk: assert (edge_ok);
    // R3
    trace_last_chk: assert (trace_ok);
  end
endmodule

bind dxq_decode_xfer dxq_decode_xfer_chk #(
  .DW(DECODE_WIDTH), .WIN(MAX_MOVE), .UQ_SIZE(UQ_SIZE), .MOP_W(MOP_W),
  .OCC_W(OCC_W), .PTR_W(PTR_W)
) chk_i (
  .fq_valid(fq_valid), .fq_vis(fq_vis), .fq_trace(fq_trace), .fq_done(fq_done),
  .fq_mop(fq_mop), .uq_occ(uq_occ), .fq_pop(fq_pop),
  .uq_push_valid(uq_push_valid), .seq_err(seq_err), .act_bus(act_bus)
);

// File: tb/dxq_decode_xfer_tb_top.sv
module dxq_decode_xfer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DWD = 4, WIN = 8, USZ = 16, MW = 3, DTW = 16;
  localparam int PW = 4, OW = 5, EW = DTW + MW + 2;
  localparam int FQD = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WIN-1:0] w_valid, w_trace, w_done;
  logic [MW-1:0]  w_mop [WIN];
  logic [DTW-1:0] w_data [WIN];
  logic [OW-1:0]  occ;
  logic [WIN*MW-1:0]  mop_bus;
  logic [WIN*DTW-1:0] data_bus;
  logic [PW-1:0]      pop;
  logic [WIN-1:0]     pv;
  logic [WIN*EW-1:0]  pd;
  logic               err;

  always_comb
    for (int i = 0; i < WIN; i++) begin
      mop_bus[i*MW +: MW]    = w_mop[i];
      data_bus[i*DTW +: DTW] = w_data[i];
    end

  dxq_decode_xfer dut_i (
    .fq_valid(w_valid), .fq_trace(w_trace), .fq_done(w_done), .fq_mop(mop_bus),
    .fq_data(data_bus), .uq_occ(occ), .fq_pop(pop), .uq_push_valid(pv),
    .uq_push_data(pd), .seq_err(err)
  );

  int checks = 0, fails = 0;

  task automatic clear_win();
    w_valid = '0; w_trace = '0; w_done = '0;
    for (int i = 0; i < WIN; i++) begin w_mop[i] = '0; w_data[i] = '0; end
  endtask

  task automatic set_ent(int i, bit tr, int m, bit dn);
    w_valid[i] = 1'b1; w_trace[i] = tr; w_done[i] = dn;
    w_mop[i] = MW'(m); w_data[i] = DTW'(16'hA000 + i * 16'h0111);
  endtask

  // Reference: walk slots over the visible window
  task automatic ref_xfer(output int rp, output bit re);
    int nv, s, q;
    nv = 0;
    while (nv < WIN && w_valid[nv]) nv++;
    rp = 0; re = 1'b0; s = 0;
    while (s < DWD) begin
      if (rp >= nv) break;
      if (int'(occ) + rp >= USZ) break;
      s++;
      if (w_trace[rp]) begin
        while (rp < nv && w_trace[rp]) rp++;
        break;
      end
      if (w_mop[rp] != 0) re = 1'b1;
      if (!w_done[rp]) continue;
      q = rp + 1;
      while (q < nv && w_mop[q] != 0) q++;
      if (q == WIN) break;
      rp = q;
    end
  endtask

  task automatic check(string tag, int e_pop, bit e_err);
    logic [EW-1:0] exp_ent;
    bit lane_bad;
    #1;
    checks++;
    if (int'(pop) != e_pop) begin
      fails++;
      $display("FAIL %s fq_pop actual=%0d expected=%0d", tag, pop, e_pop);
    end
    checks++;
    if (err != e_err) begin
      fails++;
      $display("FAIL %s seq_err actual=%0b expected=%0b", tag, err, e_err);
    end
    lane_bad = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      exp_ent = (i < e_pop) ? {1'b1, w_trace[i], w_mop[i], w_data[i]} : '0;
      if (pv[i] != (i < e_pop) || pd[i*EW +: EW] != exp_ent) begin
        lane_bad = 1'b1;
        $display("FAIL R9 (%s) lane %0d actual=%0b/%h expected=%0b/%h",
                 tag, i, pv[i], pd[i*EW +: EW], (i < e_pop), exp_ent);
      end
    end
    checks++;
    if (lane_bad) fails++;
  endtask

  // Fetch queue model for the random phase
  bit         fq_tr  [FQD];
  int         fq_mp  [FQD];
  bit         fq_dn  [FQD];
  int         fcnt;
  int         uocc;

  task automatic refill();
    int len; bit tr; bit dn;
    while (fcnt <= FQD - 8) begin
      tr  = ($urandom_range(0, 3) == 0);
      len = $urandom_range(1, tr ? 3 : 4);
      dn  = $urandom_range(0, 1);
      for (int k = 0; k < len; k++) begin
        fq_tr[fcnt] = tr; fq_mp[fcnt] = tr ? 0 : k; fq_dn[fcnt] = dn;
        fcnt++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rp; bit re; int lim; int drain;
    void'($urandom(32'h00C0FFEE));
    clear_win(); occ = '0;
    repeat (3) @(negedge clk);
    check("R1 reset empty", 0, 1'b0);
    rst_n = 1'b1;

    // R1: width limit on single-entry instructions
    @(negedge clk); clear_win(); occ = 0;
    for (int i = 0; i < 5; i++) set_ent(i, 0, 0, 1);
    check("R1 width", 4, 1'b0);

    // R6: group starting at occupancy 15 overshoots
    @(negedge clk); clear_win(); occ = 15;
    for (int i = 0; i < 8; i++) set_ent(i, 0, i % 3, 1);
    check("R6 overshoot", 3, 1'b0);

    // R2: at capacity and one below
    @(negedge clk); clear_win(); occ = 16;
    for (int i = 0; i < 8; i++) set_ent(i, 0, 0, 1);
    check("R2 full", 0, 1'b0);
    @(negedge clk); occ = 14;
    check("R2 near full", 2, 1'b0);

    // R3: trace run ends the cycle
    @(negedge clk); clear_win(); occ = 0;
    for (int i = 0; i < 3; i++) set_ent(i, 1, 0, 1);
    set_ent(3, 0, 0, 1);
    check("R3 trace run", 3, 1'b0);
    @(negedge clk); clear_win();
    for (int i = 0; i < 8; i++) set_ent(i, 1, 0, 0);
    check("R3 full window run", 8, 1'b0);

    // R4: group then trace run
    @(negedge clk); clear_win();
    for (int i = 0; i < 3; i++) set_ent(i, 0, i, 1);
    set_ent(3, 1, 0, 1); set_ent(4, 1, 0, 1); set_ent(5, 0, 0, 1);
    check("R4 group then trace", 5, 1'b0);

    // R5: fetch in flight blocks everything
    @(negedge clk); clear_win();
    set_ent(0, 0, 0, 0);
    for (int i = 1; i < 5; i++) set_ent(i, 0, 0, 1);
    check("R5 in flight", 0, 1'b0);

    // R7: group fills window vs closed by invalid lane
    @(negedge clk); clear_win();
    for (int i = 0; i < 8; i++) set_ent(i, 0, i, 1);
    check("R7 held", 0, 1'b0);
    @(negedge clk); w_valid[7] = 1'b0;
    check("R7 closed", 7, 1'b0);

    // R8: misnumbered head still moves
    @(negedge clk); clear_win();
    set_ent(0, 0, 2, 1); set_ent(1, 0, 0, 1);
    check("R8 bad head", 2, 1'b1);

    // R10: broken valid prefix
    @(negedge clk); clear_win();
    set_ent(0, 0, 0, 1); set_ent(2, 0, 0, 1); set_ent(3, 0, 0, 1);
    check("R10 prefix", 1, 1'b0);

    // Random streams against the reference
    fcnt = 0; uocc = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      refill();
      lim = ($urandom_range(0, 3) == 0) ? $urandom_range(0, WIN) : WIN;
      clear_win();
      for (int i = 0; i < WIN; i++)
        if (i < lim && i < fcnt) begin
          w_valid[i] = 1'b1; w_trace[i] = fq_tr[i]; w_done[i] = fq_dn[i];
          w_mop[i] = MW'(fq_mp[i]); w_data[i] = DTW'(cyc * 8 + i);
        end
      occ = OW'(uocc);
      ref_xfer(rp, re);
      check("R9 random", rp, re);
      for (int k = 0; k + rp < fcnt; k++) begin
        fq_tr[k] = fq_tr[k+rp]; fq_mp[k] = fq_mp[k+rp]; fq_dn[k] = fq_dn[k+rp];
      end
      fcnt -= rp;
      uocc += rp;
      drain = $urandom_range(0, 4);
      uocc = (uocc > drain) ? uocc - drain : 0;
      for (int k = 0; k < fcnt; k++)
        if (!fq_dn[k] && $urandom_range(0, 2) == 0) fq_dn[k] = 1'b1;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule